// File: doc/BRIEF.md
# Two-Stage Stream Width Converter Through a Common-Multiple Register

This block moves a valid/ready data stream from one bus width to another when neither width divides the other. The stream passes through a register whose width is the least common multiple of the two widths. A packing stage gathers narrow input beats into that wide word. An unpacking stage then slices the wide word into output beats. Both stages preserve little-endian bit order.

A transfer is a fixed number of bits, set by a parameter that must be a whole multiple of both widths. The host pulses a start input together with a repetition count. The block then accepts exactly that many transfers' worth of input beats and emits the same number of transfers on the output. The output's last flag marks the end of each transfer. A busy output stays high until the final output beat has been taken.

Top module: `lcm_width_converter`

## Requirements
- R1: The intermediate word is IN_W*OUT_W/gcd(IN_W,OUT_W) bits wide. With IN_W=32 and OUT_W=24 this is 96 bits, so the first three 32-bit input beats come out as the first four 24-bit output beats.
- R2: Input beat k occupies bits [k*IN_W +: IN_W] of the input bit stream, and output beat j carries bits [j*OUT_W +: OUT_W] of that same stream. The least significant slice leaves first.
- R3: `m_last` is 1 on an output beat exactly when that beat is the final one, TOTAL_BITS/OUT_W, of its transfer, and 0 on every other beat.
- R4: After a start with count N, exactly N*TOTAL_BITS/IN_W input beats are accepted and exactly N*TOTAL_BITS/OUT_W output beats are produced. `s_ready` is 0 once all input beats have been taken.
- R5: A start pulse while `busy_o` is 1 is ignored, and the number of beats in the current run does not change.
- R6: A start with a count of 0 begins nothing: `busy_o` stays 0 and no beats are accepted or produced.
- R7: While `m_valid` is 1 and `m_ready` is 0, `m_valid`, `m_data` and `m_last` hold their values into the next cycle.
- R8: When input is always valid and `m_ready` is always 1, `m_valid` stays high on every cycle from the first output beat until the last beat of the run.
- R9: `busy_o` rises in the cycle after an accepted start with a nonzero count and falls in the cycle after the final output beat is taken. No output beat is valid while `busy_o` is 0.
- R10: After reset, `busy_o`, `m_valid` and `s_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Starts a run when idle |
| reps_i | input | REP_W | Number of transfers in the run |
| busy_o | output | 1 | Run in progress |
| s_valid | input | 1 | Input beat valid |
| s_data | input | IN_W | Input beat data |
| s_ready | output | 1 | Input beat accepted |
| m_valid | output | 1 | Output beat valid |
| m_data | output | OUT_W | Output beat data |
| m_last | output | 1 | Final beat of a transfer |
| m_ready | input | 1 | Output beat taken |

## Verification
The bench builds the block with 32-bit input, 24-bit output and 192 bits per transfer. This gives a 96-bit intermediate word, six input beats and eight output beats per transfer, and two intermediate words per transfer. It sweeps repetition counts 0 to 3, plus the largest count, against three input-valid patterns and three output-ready patterns. This covers packer and unpacker stalls, back-to-back transfers, a start pulse that arrives mid-run, and the zero-count case.

// File: rtl/lcmw_pkg.sv
`timescale 1ns/1ps
// Package: width arithmetic shared by the converter stages.
// Assumes positive widths; evaluated only at elaboration.
package lcmw_pkg;
    // Greatest common divisor by Euclid's method.
    function automatic int gcd_f(input int a, input int b);
        int x, y, t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    // Least common multiple of two widths.
    function automatic int lcm_f(input int a, input int b);
        return (a / gcd_f(a, b)) * b;
    endfunction
endpackage

// File: rtl/stream_packer.sv
`timescale 1ns/1ps
// Module: stream_packer
// Gathers MID_W/IN_W narrow beats into one wide word, first beat in the
// least significant slot. Assumes MID_W is a whole multiple of IN_W.
// Accepts a new beat in the same cycle its full word is handed on.
module stream_packer #(
    parameter int IN_W  = 32,
    parameter int MID_W = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    output logic             in_ready,
    output logic             mid_valid,
    output logic [MID_W-1:0] mid_data,
    input  logic             mid_ready
);
    localparam int SLOTS = MID_W / IN_W;
    localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

    logic [MID_W-1:0] acc;
    logic [SW-1:0]    slot;
    logic             full;
    logic             accept;
    logic             take;

    assign take      = full && mid_ready;
    assign in_ready  = !full || mid_ready;
    assign accept    = in_valid && in_ready;
    assign mid_valid = full;
    assign mid_data  = acc;

    // Write the incoming beat into its slot and advance the slot index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            slot <= '0;
        end else if (accept) begin
            acc[slot*IN_W +: IN_W] <= in_data;
            slot <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
        end
    end

    // Track whether a completed word is waiting for the unpacker.
    always_ff @(posedge clk) begin
        if (!rst_n)
            full <= 1'b0;
        else if (accept && slot == LAST_SLOT)
            full <= 1'b1;
        else if (take)
            full <= 1'b0;
    end

    // A finished word that is not taken stays intact (R7 chain).
    assert_mid_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_valid && !mid_ready) |=> (mid_valid && $stable(mid_data)));
endmodule

// File: rtl/stream_unpacker.sv
`timescale 1ns/1ps
// Module: stream_unpacker
// Slices a wide word into MID_W/OUT_W output beats, least significant
// slice first, and flags the final beat of each BEATS_PER_REP-beat transfer.
// Assumes MID_W is a whole multiple of OUT_W. It loads the next word in the
// cycle the last slice leaves, so a ready consumer sees no bubbles.
module stream_unpacker #(
    parameter int MID_W         = 96,
    parameter int OUT_W         = 24,
    parameter int BEATS_PER_REP = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mid_valid,
    input  logic [MID_W-1:0] mid_data,
    output logic             mid_ready,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data,
    output logic             out_last,
    input  logic             out_ready
);
    localparam int SLICES = MID_W / OUT_W;
    localparam int XW     = (SLICES > 1) ? $clog2(SLICES) : 1;
    localparam int BW     = (BEATS_PER_REP > 1) ? $clog2(BEATS_PER_REP) : 1;
    localparam logic [XW-1:0] LAST_IDX  = XW'(SLICES - 1);
    localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS_PER_REP - 1);

    logic [MID_W-1:0] word;
    logic [XW-1:0]    idx;
    logic [BW-1:0]    beat;
    logic             full;
    logic             fire;
    logic             load;

    assign fire      = full && out_ready;
    assign mid_ready = !full || (out_ready && idx == LAST_IDX);
    assign load      = mid_valid && mid_ready;
    assign out_valid = full;
    assign out_data  = word[idx*OUT_W +: OUT_W];
    assign out_last  = (beat == LAST_BEAT);

    // Hold the current wide word and step through its slices.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
            idx  <= '0;
            full <= 1'b0;
        end else if (load) begin
            word <= mid_data;
            idx  <= '0;
            full <= 1'b1;
        end else if (fire) begin
            idx  <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
            full <= (idx != LAST_IDX);
        end
    end

    // Count output beats within a transfer to place the last flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            beat <= '0;
        else if (fire)
            beat <= (beat == LAST_BEAT) ? '0 : beat + 1'b1;
    end

    // Output held steady under back-pressure.
    assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

// File: rtl/lcm_width_converter.sv
`timescale 1ns/1ps
// Module: lcm_width_converter (top)
// Converts an IN_W stream to an OUT_W stream through a register of
// lcm(IN_W, OUT_W) bits, for a run of reps_i transfers of TOTAL_BITS each.
// Assumes both widths are multiples of 8 and TOTAL_BITS is a multiple of
// both widths, and therefore of their least common multiple.
module lcm_width_converter #(
    parameter int IN_W       = 32,
    parameter int OUT_W      = 24,
    parameter int TOTAL_BITS = 192,
    parameter int REP_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [REP_W-1:0] reps_i,
    output logic             busy_o,
    input  logic             s_valid,
    input  logic [IN_W-1:0]  s_data,
    output logic             s_ready,
    output logic             m_valid,
    output logic [OUT_W-1:0] m_data,
    output logic             m_last,
    input  logic             m_ready
);
    import lcmw_pkg::*;

    localparam int MID_W    = lcm_f(IN_W, OUT_W);
    localparam int IN_BEATS = TOTAL_BITS / IN_W;
    localparam int OUT_BEATS = TOTAL_BITS / OUT_W;
    localparam int IBW      = (IN_BEATS > 1) ? $clog2(IN_BEATS) : 1;
    localparam logic [IBW-1:0] LAST_IN = IBW'(IN_BEATS - 1);

    logic [REP_W-1:0] in_left;
    logic [REP_W-1:0] out_left;
    logic [IBW-1:0]   in_beat;
    logic             in_active;
    logic             pk_in_ready;
    logic             in_fire;
    logic             out_fire;
    logic             mid_valid;
    logic             mid_ready;
    logic [MID_W-1:0] mid_data;

    assign in_active = (in_left != '0);
    assign busy_o    = (out_left != '0);
    assign s_ready   = pk_in_ready && in_active;
    assign in_fire   = s_valid && s_ready;
    assign out_fire  = m_valid && m_ready;

    stream_packer #(.IN_W(IN_W), .MID_W(MID_W)) packer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (s_valid && in_active),
        .in_data   (s_data),
        .in_ready  (pk_in_ready),
        .mid_valid (mid_valid),
        .mid_data  (mid_data),
        .mid_ready (mid_ready)
    );

    stream_unpacker #(.MID_W(MID_W), .OUT_W(OUT_W), .BEATS_PER_REP(OUT_BEATS)) unpacker_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mid_valid (mid_valid),
        .mid_data  (mid_data),
        .mid_ready (mid_ready),
        .out_valid (m_valid),
        .out_data  (m_data),
        .out_last  (m_last),
        .out_ready (m_ready)
    );

    // Load repetition counts on start and retire transfers on each side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_left  <= '0;
            out_left <= '0;
            in_beat  <= '0;
        end else if (start_i && !busy_o) begin
            in_left  <= reps_i;
            out_left <= reps_i;
            in_beat  <= '0;
        end else begin
            if (in_fire) begin
                if (in_beat == LAST_IN) begin
                    in_beat <= '0;
                    in_left <= in_left - 1'b1;
                end else begin
                    in_beat <= in_beat + 1'b1;
                end
            end
            if (out_fire && m_last)
                out_left <= out_left - 1'b1;
        end
    end

    // Output side never finishes transfers ahead of the input side.
    assert_side_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_left >= in_left);

    // No output beat outside a run.
    assert_valid_in_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> busy_o);

    // A start during a run leaves the remaining count alone.
    assert_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !(out_fire && m_last)) |=> $stable(out_left));

    // An idle block accepts no input.
    assert_idle_no_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !s_ready);
endmodule

// File: tb/lcm_width_converter_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps repetition counts and handshake patterns on a 32->96->24
// configuration and compares every output beat with a bit-stream model.
module lcm_width_converter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int IN_W       = 32;
    localparam int OUT_W      = 24;
    localparam int TOTAL_BITS = 192;
    localparam int REP_W      = 4;
    localparam int IN_PER     = TOTAL_BITS / IN_W;
    localparam int OUT_PER    = TOTAL_BITS / OUT_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [REP_W-1:0] reps_i = '0;
    logic             busy_o;
    logic             s_valid = 1'b0;
    logic [IN_W-1:0]  s_data = '0;
    logic             s_ready;
    logic             m_valid;
    logic [OUT_W-1:0] m_data;
    logic             m_last;
    logic             m_ready = 1'b0;

    int errors = 0;
    int checks = 0;
    int salt = 0;
    logic [15:0] lfsr = 16'hACE1;

    lcm_width_converter #(
        .IN_W(IN_W), .OUT_W(OUT_W), .TOTAL_BITS(TOTAL_BITS), .REP_W(REP_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .reps_i(reps_i),
        .busy_o(busy_o), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .m_valid(m_valid), .m_data(m_data), .m_last(m_last), .m_ready(m_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] in_word(input int k);
        return (32'(k) * 32'h0100_0193) ^ (32'(salt) * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic logic [23:0] exp_out(input int j);
        int bp, w, off;
        logic [63:0] pair;
        bp   = 24 * j;
        w    = bp / 32;
        off  = bp % 32;
        pair = {in_word(w + 1), in_word(w)};
        pair = pair >> off;
        return pair[23:0];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run(input int reps, input int vm, input int rm);
        int in_cnt, out_cnt, gaps, cyc, tail;
        bit hold, done;
        logic [23:0] hold_d;
        logic hold_l;
        in_cnt = 0; out_cnt = 0; gaps = 0; cyc = 0; tail = 0;
        hold = 0; hold_d = '0; hold_l = 1'b0;
        salt++;
        @(negedge clk);
        start_i = 1'b1; reps_i = REP_W'(reps); s_valid = 1'b0; m_ready = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == (reps != 0), "R9", "busy after start", 64'(busy_o), 64'(reps != 0));
        done = (reps == 0);
        while (tail < 12 && cyc < 3000) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            s_valid = (vm == 0) ? 1'b1 : (vm == 1) ? (cyc % 2 == 0) : lfsr[0];
            s_data  = in_word(in_cnt);
            m_ready = (rm == 0) ? 1'b1 : (rm == 1) ? (cyc % 2 == 1) : lfsr[3];
            start_i = (cyc == 4) && (reps != 0);
            reps_i  = REP_W'(3);
            #1;
            if (hold)
                chk(m_valid && m_data == hold_d && m_last == hold_l, "R7", "held beat",
                    {39'd0, m_valid, m_data}, {39'd1, 1'b1, hold_d});
            hold = m_valid && !m_ready;
            hold_d = m_data;
            hold_l = m_last;
            if (s_valid && s_ready) in_cnt++;
            if (vm == 0 && rm == 0 && out_cnt > 0 && !done && !m_valid) gaps++;
            if (m_valid && m_ready) begin
                chk(m_data == exp_out(out_cnt), (out_cnt < 4) ? "R1" : "R2", "data",
                    64'(m_data), 64'(exp_out(out_cnt)));
                chk(m_last == ((out_cnt % OUT_PER) == OUT_PER - 1), "R3", "last",
                    64'(m_last), 64'((out_cnt % OUT_PER) == OUT_PER - 1));
                out_cnt++;
            end
            if (out_cnt >= reps * OUT_PER) done = 1;
            if (done) tail++;
            cyc++;
            @(negedge clk);
        end
        start_i = 1'b0; s_valid = 1'b0; m_ready = 1'b0;
        #1;
        chk(in_cnt == reps * IN_PER, "R4", "input beats", 64'(in_cnt), 64'(reps * IN_PER));
        chk(out_cnt == reps * OUT_PER, "R5", "output beats", 64'(out_cnt), 64'(reps * OUT_PER));
        chk(busy_o == 1'b0, "R9", "busy at end", 64'(busy_o), 64'd0);
        chk(s_ready == 1'b0, "R4", "ready at end", 64'(s_ready), 64'd0);
        if (vm == 0 && rm == 0)
            chk(gaps == 0, "R8", "bubbles", 64'(gaps), 64'd0);
        if (reps == 0)
            chk(in_cnt == 0 && out_cnt == 0, "R6", "zero-count beats",
                64'(in_cnt + out_cnt), 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!busy_o && !m_valid && !s_ready, "R10", "reset state",
            {61'd0, busy_o, m_valid, s_ready}, 64'd0);
        for (int r = 0; r < 4; r++)
            for (int v = 0; v < 3; v++)
                for (int m = 0; m < 3; m++)
                    run(r, v, m);
        run(15, 0, 0);
        run(15, 2, 2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule